// File: doc/BRIEF.md
# Stereo ADC Serial Output Port

This block is the serial audio output stage of a stereo converter. A pair of 24-bit two's complement samples, left and right, arrives in parallel with a one-cycle valid strobe and a per-channel overflow flag. The block shifts each pair out on a single data pin, MSB first, inside a 64-bit frame split into two 32-bit halves. A format input chooses between left-justified framing and I2S framing.

As clock master, the block derives the bit clock and frame clock from its core clock through a divide table set by a 2-bit speed code, with an optional stage that halves the master clock. The core clock `clk` runs at twice the master clock rate, so the fastest bit clock can be built from flops. As clock slave, it samples the external bit and frame clocks with the core clock, detects their edges and follows them. It ignores the halving input in that mode. After reset it sends zeros for a fixed number of frames, while the analog reference settles.

Top module: `adc_serial_port`

## Requirements
- R1: While `rst_n` is low, `sdout` and `ovf_o` are 0. In master mode `sclk_o` is held at 1 and `lrck_o` is held at the right-channel level (0 for left-justified, 1 for I2S). In slave mode both clock outputs are 0 and `clk_oe` follows `ms_master`.
- R2: In master mode each half period of `sclk_o` lasts H core cycles, with H = 4 for speed code 00, 2 for 01 and 1 for 10. Code 11 behaves as 00. The first falling edge comes H cycles after reset is released.
- R3: In master mode, `pre_div` = 1 doubles H. This doubles every master-clock-to-sample-rate ratio.
- R4: In master mode `lrck_o` changes only together with a falling edge of `sclk_o`, once every 32 bit periods. A frame is 64 bit periods and begins with the left half.
- R5: Left-justified (`fmt_lj` = 1): the left half is sent while `lrck_o` is 1, and the MSB is in slot 0 of each half.
- R6: I2S (`fmt_lj` = 0): the left half is sent while `lrck_o` is 0, and the MSB is in slot 1 of each half.
- R7: Each half carries 24 bits MSB first. Every slot that holds no sample bit is 0: slots 24..31 in left-justified format, and slots 0 and 25..31 in I2S format.
- R8: `sdout` changes only on a falling edge of the bit clock.
- R9: `smp_valid` captures `smp_left` and `smp_right`. The pair held at the start of a left half is the pair sent in that frame.
- R10: The first MUTE_FRAMES frames after reset carry zeros in both halves, whatever samples were supplied. The default is 2 frames.
- R11: One cycle after `smp_valid`, `ovf_o` equals the OR of `ovf_left` and `ovf_right` from that strobe. It holds that value until the next strobe.
- R12: In slave mode `clk_oe`, `sclk_o` and `lrck_o` are 0. `sdout` takes the value for a slot three core cycles after the external `sclk_i` falls. A change of `lrck_i` restarts the slot count at 0, and the level of `lrck_i` selects the channel, as in R5 and R6.
- R13: In slave mode `pre_div` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master clock rate |
| rst_n | input | 1 | Active-low reset, idles the port |
| ms_master | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| pre_div | input | 1 | Halve master clock (master mode only) |
| spd_sel | input | 2 | Speed code: 00 single, 01 double, 10 quad |
| fmt_lj | input | 1 | 1 = left-justified, 0 = I2S |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| ovf_left | input | 1 | Left overflow flag |
| ovf_right | input | 1 | Right overflow flag |
| sclk_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External frame clock (slave) |
| sclk_o | output | 1 | Generated bit clock (master) |
| lrck_o | output | 1 | Generated frame clock (master) |
| clk_oe | output | 1 | Clock pin drive enable |
| sdout | output | 1 | Serial data |
| ovf_o | output | 1 | Overflow indication |

## Verification
The bench targets the one-slot shift of I2S. A design that gets it wrong puts the MSB in slot 0, or drops the last bit into slot 25, and fails every data slot. It also checks the channel polarity of the frame clock in both formats; a swapped polarity sends the right sample while the left is expected. Each divide ratio is run, including the reserved code and the halving stage, and the halving stage is also applied in slave mode, where honouring it would shift every slave bit. The mute window and the frame-start load point are compared bit for bit, so loading mid-frame or unmuting one frame early shows up at once.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    localparam int HALF_W = 4;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } spd_e;

    // half bit-clock period in core cycles
    function automatic logic [HALF_W-1:0] half_len(input logic [1:0] spd, input logic dbl);
        logic [HALF_W-1:0] b;
        case (spd_e'(spd))
            SPD_DOUBLE: b = HALF_W'(2);
            SPD_QUAD:   b = HALF_W'(1);
            default:    b = HALF_W'(4);
        endcase
        return dbl ? (b << 1) : b;
    endfunction

endpackage

// File: rtl/adc_sp_tick.sv
module adc_sp_tick #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] len,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= len - 1'b1) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic lrck_in,
    output logic fall,
    output logic lrck_lvl
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] lrk;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < STAGES; i++) begin
            if (i == 0) begin
                st_d.sck[i] = sclk_in;
                st_d.lrk[i] = lrck_in;
            end else begin
                st_d.sck[i] = st_q.sck[i-1];
                st_d.lrk[i] = st_q.lrk[i-1];
            end
        end
        st_d.prev = st_q.sck[STAGES-1];
        fall      = st_q.prev & ~st_q.sck[STAGES-1];
        lrck_lvl  = st_q.lrk[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck  <= '1;
            st_q.lrk  <= '0;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/adc_sp_ser.sv
module adc_sp_ser #(
    parameter int SMP_W       = 24,
    parameter int SLOT_N      = 32,
    parameter int MUTE_FRAMES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic             fmt_lj,
    input  logic             adv,
    input  logic             s_fall,
    input  logic             s_lrck,
    input  logic [SMP_W-1:0] hold_l,
    input  logic [SMP_W-1:0] hold_r,
    output logic             sclk_o,
    output logic             lrck_o,
    output logic             sdout
);
    localparam int POS_W  = $clog2(2 * SLOT_N);
    localparam int MUTE_W = $clog2(MUTE_FRAMES + 2);
    localparam int IDX_W  = $clog2(SMP_W);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_N - 1);
    localparam logic [POS_W-1:0] POS_MAX  = POS_W'(2 * SLOT_N - 1);
    localparam logic [MUTE_W-1:0] MUTE_N  = MUTE_W'(MUTE_FRAMES);

    typedef struct packed {
        logic              half;
        logic [POS_W-1:0]  pos;
        logic              left;
        logic              lr_last;
        logic [SMP_W-1:0]  fl;
        logic [SMP_W-1:0]  fr;
        logic [MUTE_W-1:0] mcnt;
        logic              sd;
    } st_t;

    st_t st_d, st_q;

    function automatic logic pick(input logic [SMP_W-1:0] w, input logic [POS_W-1:0] p,
                                  input logic lj);
        int k;
        logic [IDX_W-1:0] idx;
        k = lj ? int'(p) : int'(p) - 1;
        if (k < 0 || k >= SMP_W) return 1'b0;
        idx = IDX_W'(SMP_W - 1 - k);
        return w[idx];
    endfunction

    logic             fall;
    logic [POS_W-1:0] npos;
    logic             nleft;
    logic [SMP_W-1:0] wl, wr;

    always_comb begin
        st_d  = st_q;
        fall  = 1'b0;
        npos  = st_q.pos;
        nleft = st_q.left;
        wl    = st_q.fl;
        wr    = st_q.fr;
        if (master) begin
            if (adv) begin
                st_d.half = ~st_q.half;
                if (st_q.half) begin
                    fall = 1'b1;
                    if (st_q.pos >= POS_LAST) begin
                        npos  = '0;
                        nleft = ~st_q.left;
                    end else begin
                        npos = st_q.pos + 1'b1;
                    end
                end
            end
        end else if (s_fall) begin
            fall         = 1'b1;
            nleft        = fmt_lj ? s_lrck : ~s_lrck;
            st_d.lr_last = s_lrck;
            if (s_lrck != st_q.lr_last) npos = '0;
            else if (st_q.pos != POS_MAX) npos = st_q.pos + 1'b1;
        end
        if (fall) begin
            st_d.pos  = npos;
            st_d.left = nleft;
            if (npos == '0 && nleft) begin
                if (st_q.mcnt < MUTE_N) begin
                    wl        = '0;
                    wr        = '0;
                    st_d.mcnt = st_q.mcnt + 1'b1;
                end else begin
                    wl = hold_l;
                    wr = hold_r;
                end
                st_d.fl = wl;
                st_d.fr = wr;
            end
            st_d.sd = pick(nleft ? wl : wr, npos, fmt_lj);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.half <= 1'b1;
            st_q.pos  <= POS_LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o = master & st_q.half;
    assign lrck_o = master & (fmt_lj ? st_q.left : ~st_q.left);
    assign sdout  = st_q.sd;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
    parameter int SMP_W       = 24,
    parameter int SLOT_N      = 32,
    parameter int MUTE_FRAMES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_master,
    input  logic             pre_div,
    input  logic [1:0]       spd_sel,
    input  logic             fmt_lj,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    input  logic             ovf_left,
    input  logic             ovf_right,
    input  logic             sclk_i,
    input  logic             lrck_i,
    output logic             sclk_o,
    output logic             lrck_o,
    output logic             clk_oe,
    output logic             sdout,
    output logic             ovf_o
);
    import adc_sp_pkg::*;

    typedef struct packed {
        logic [SMP_W-1:0] hl;
        logic [SMP_W-1:0] hr;
        logic             ovf;
    } st_t;

    st_t st_d, st_q;

    logic [HALF_W-1:0] hlen;
    logic              adv;
    logic              s_fall;
    logic              s_lrck;

    always_comb begin
        st_d = st_q;
        if (smp_valid) begin
            st_d.hl  = smp_left;
            st_d.hr  = smp_right;
            st_d.ovf = ovf_left | ovf_right;
        end
        hlen = half_len(spd_sel, pre_div & ms_master);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    adc_sp_tick #(.CNT_W(HALF_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ms_master),
        .len   (hlen),
        .tick  (adv)
    );

    adc_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_in  (sclk_i),
        .lrck_in  (lrck_i),
        .fall     (s_fall),
        .lrck_lvl (s_lrck)
    );

    adc_sp_ser #(
        .SMP_W       (SMP_W),
        .SLOT_N      (SLOT_N),
        .MUTE_FRAMES (MUTE_FRAMES)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .master  (ms_master),
        .fmt_lj  (fmt_lj),
        .adv     (adv),
        .s_fall  (s_fall),
        .s_lrck  (s_lrck),
        .hold_l  (st_q.hl),
        .hold_r  (st_q.hr),
        .sclk_o  (sclk_o),
        .lrck_o  (lrck_o),
        .sdout   (sdout)
    );

    assign clk_oe = ms_master;
    assign ovf_o  = st_q.ovf;
endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk (
    input logic clk,
    input logic rst_n,
    input logic ms_master,
    input logic fmt_lj,
    input logic smp_valid,
    input logic ovf_left,
    input logic ovf_right,
    input logic sclk_o,
    input logic lrck_o,
    input logic clk_oe,
    input logic sdout,
    input logic ovf_o
);
    logic seen = 1'b0;
    always_ff @(posedge clk) seen <= 1'b1;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!seen)
        !rst_n |-> (!sdout && !ovf_o)); // R1

    AST_OVF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (ovf_o == $past(ovf_left || ovf_right))); // R11

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_master && $past(ms_master) && $past(rst_n) && !$stable(sdout)) |-> $fell(sclk_o)); // R8

    AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_master && $past(ms_master) && $past(rst_n) && $stable(fmt_lj) && !$stable(lrck_o))
        |-> $fell(sclk_o)); // R4

    AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_master |-> (!clk_oe && !sclk_o && !lrck_o)); // R12
endmodule

bind adc_serial_port adc_sp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_master (ms_master),
    .fmt_lj    (fmt_lj),
    .smp_valid (smp_valid),
    .ovf_left  (ovf_left),
    .ovf_right (ovf_right),
    .sclk_o    (sclk_o),
    .lrck_o    (lrck_o),
    .clk_oe    (clk_oe),
    .sdout     (sdout),
    .ovf_o     (ovf_o)
);

// File: tb/tb_adc_serial_port.sv
`timescale 1ns/1ps
module tb_adc_serial_port;
    localparam int MUTE = 2;
    localparam int WD   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_master = 1'b1;
    logic        pre_div = 1'b0;
    logic [1:0]  spd_sel = 2'b00;
    logic        fmt_lj = 1'b1;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        ovf_left = 1'b0;
    logic        ovf_right = 1'b0;
    logic        sclk_i = 1'b1;
    logic        lrck_i = 1'b0;
    logic        sclk_o, lrck_o, clk_oe, sdout, ovf_o;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    logic exp_ovf = 1'b0;

    always #2 clk = ~clk;

    adc_serial_port dut (
        .clk(clk), .rst_n(rst_n), .ms_master(ms_master), .pre_div(pre_div),
        .spd_sel(spd_sel), .fmt_lj(fmt_lj), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .ovf_left(ovf_left),
        .ovf_right(ovf_right), .sclk_i(sclk_i), .lrck_i(lrck_i),
        .sclk_o(sclk_o), .lrck_o(lrck_o), .clk_oe(clk_oe), .sdout(sdout), .ovf_o(ovf_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD) begin
            nfail++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [23:0] samp(input int fi, input int ch);
        logic [31:0] x;
        x = fi * 32'h9E3779B1 + ch * 32'h7F4A7C15 + 32'h00C0FFEE;
        return x[31:8];
    endfunction

    // expected data bit for global slot p (64 slots per frame, left half first)
    function automatic logic exp_bit(input int p, input logic lj);
        int fi, pos, k;
        logic [23:0] w;
        if (p < 0) return 1'b0;
        fi  = p / 64;
        pos = p % 32;
        k   = lj ? pos : pos - 1;
        if (k < 0 || k >= 24) return 1'b0;
        w = (fi < MUTE) ? 24'h0 : samp(fi, ((p % 64) < 32) ? 0 : 1);
        return w[23 - k];
    endfunction

    function automatic string bit_tag(input int p, input logic lj, input logic on_fall);
        int pos, k;
        if (p < 0) return "R2";
        pos = p % 32;
        k   = lj ? pos : pos - 1;
        if (p / 64 < MUTE) return "R10";
        if (k < 0 || k >= 24) return "R7";
        if (k == 0) return lj ? "R5" : "R6";
        if (!on_fall) return "R8";
        return "R9";
    endfunction

    task automatic feed(input int fi);
        smp_valid = 1'b1;
        smp_left  = samp(fi, 0);
        smp_right = samp(fi, 1);
        ovf_left  = (fi % 2) == 1;
        ovf_right = ((fi / 2) % 2) == 1;
    endtask

    task automatic do_reset(input logic m, input logic [1:0] spd, input logic dv, input logic lj);
        @(negedge clk);
        rst_n     = 1'b0;
        ms_master = m;
        spd_sel   = spd;
        pre_div   = dv;
        fmt_lj    = lj;
        smp_valid = 1'b0;
        sclk_i    = 1'b1;
        lrck_i    = lj ? 1'b0 : 1'b1;
        exp_ovf   = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", "sdout in reset", sdout, 1'b0);
            chk("R1", "ovf_o in reset", ovf_o, 1'b0);
            chk("R1", "sclk_o in reset", sclk_o, m);
            chk("R1", "lrck_o in reset", lrck_o, m & ~lj);
            chk("R1", "clk_oe in reset", clk_oe, m);
        end
        rst_n = 1'b1;
    endtask

    task automatic run_master(input logic [1:0] spd, input logic dv, input logic lj, input int frames);
        int h, fed;
        h = (spd == 2'b01) ? 2 : (spd == 2'b10) ? 1 : 4;
        if (dv) h = h * 2;
        fed = -1;
        do_reset(1'b1, spd, dv, lj);
        for (int e = 1; e <= frames * 128 * h; e++) begin
            int n, p;
            logic left, on_fall;
            @(negedge clk);
            n = e / h;
            p = (n + 1) / 2 - 1;
            on_fall = (e % h == 0) && (n % 2 == 1);
            left = (p >= 0) && ((p % 64) < 32);
            chk(dv ? "R3" : "R2", "sclk_o", sclk_o, (n % 2) == 0);
            chk("R4", "lrck_o", lrck_o, lj ? left : ~left);
            chk(bit_tag(p, lj, on_fall), "sdout", sdout, exp_bit(p, lj));
            chk("R11", "ovf_o", ovf_o, exp_ovf);
            chk("R1", "clk_oe master", clk_oe, 1'b1);
            smp_valid = 1'b0;
            if (p >= 0 && (p % 64) == 40 && fed != p / 64) begin
                fed = p / 64;
                feed(fed + 1);
                exp_ovf = ovf_left | ovf_right;
            end
        end
    endtask

    task automatic run_slave(input logic lj, input logic dv, input int frames);
        int q, fed;
        logic t;
        logic [2:0] dl;
        logic lvl_l, lvl_r;
        lvl_l = lj;
        lvl_r = ~lj;
        q = -5;
        fed = -1;
        t = 1'b0;
        dl = '0;
        do_reset(1'b0, 2'b00, dv, lj);
        for (int c = 0; c < (frames * 64 + 5) * 8 + 8; c++) begin
            @(negedge clk);
            chk(dv ? "R13" : "R12", "slave sdout", sdout, dl[2]);
            chk("R12", "slave clk_oe", clk_oe, 1'b0);
            chk("R12", "slave sclk_o", sclk_o, 1'b0);
            chk("R12", "slave lrck_o", lrck_o, 1'b0);
            chk("R11", "slave ovf_o", ovf_o, exp_ovf);
            smp_valid = 1'b0;
            if (c % 8 == 0) begin
                q++;
                sclk_i = 1'b0;
                lrck_i = (q < 0) ? lvl_r : (((q % 64) < 32) ? lvl_l : lvl_r);
                t = exp_bit(q, lj);
            end else if (c % 8 == 4) begin
                sclk_i = 1'b1;
            end
            if (q >= 0 && (q % 64) == 40 && (c % 8) == 2 && fed != q / 64) begin
                fed = q / 64;
                feed(fed + 1);
                exp_ovf = ovf_left | ovf_right;
            end
            dl = {dl[1:0], t};
        end
    endtask

    initial begin
        run_master(2'b00, 1'b0, 1'b1, 5);
        run_master(2'b01, 1'b0, 1'b0, 5);
        run_master(2'b10, 1'b0, 1'b1, 5);
        run_master(2'b10, 1'b1, 1'b0, 5);
        run_master(2'b11, 1'b0, 1'b0, 4);
        run_master(2'b00, 1'b1, 1'b1, 4);
        run_slave(1'b1, 1'b0, 5);
        run_slave(1'b0, 1'b1, 5);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule